// File: doc/BRIEF.md
# ATA Packet-Device Task-File Register Block

This block is the device-side register file of an optical-drive ATA/ATAPI interface. The host reads and writes byte registers through a 5-bit address. The block keeps the command parameter registers, a control register, the error register and a status byte. Behind the status byte sits a small sequencer. On every accepted command it raises BUSY for a fixed latency. It then finishes one of three ways: it opens a data phase by raising DRQ, it completes and raises an interrupt request, or it aborts with an error.

The 16-bit data port passes host PIO accesses straight through to an external sector buffer, and it does so only while DRQ is set. A separate input reports the loaded medium as a medium code ORed with state flags: audio 0x00, no disc 0x06, CD-ROM 0x20, high-density 0x80, plus 0x01 ready and 0x02 spun down. The host reads this register at the address that takes LBA bits 7:0 on a write. The SET FEATURE command picks the transfer mode from the count register.

Top module: `ata_taskfile_dev`

## Requirements
- R1: After reset, status reads 0x40, the interrupt output is low, the error register is 0 and the transfer mode is PIO (xfer_mode 0, xfer_sub 0).
- R2: While status bit 7 (BUSY) or bit 3 (DRQ) is set, host writes to every register except control (01110) are dropped. Control writes always take effect.
- R3: Reads decode as follows: 10010 count, 10100 LBA 15:8, 10101 LBA 23:16, 10110 device, 10001 error, 10011 the disc_state input. A write to 10011 loads LBA 7:0 on cmd_lba and does not change what 10011 reads. Register reads return the byte in bits 7:0 with bits 15:8 zero.
- R4: Status is read at 10111 and at 01110. Its bits are: bit 7 BUSY; bit 6 READY, which is the inverse of BUSY; bit 3 DRQ; bit 0 ERROR. All other bits read 0. BUSY and DRQ are never set together.
- R5: An accepted write to 10111 sets BUSY from the following cycle, and BUSY stays set for CMD_LAT cycles. The outcome appears as BUSY falls.
- R6: Commands 0xA0, 0xA1 and 0xA2 set DRQ at completion if buf_pending is high. Otherwise they raise the interrupt. Once DRQ is set and buf_pending goes low, DRQ clears on the next cycle and the interrupt is raised.
- R7: Address 10000 is the data port. While DRQ is set, a read returns buf_rd_data and pulses buf_rd, and a write pulses buf_wr with host_wdata on buf_wr_data. While DRQ is clear, reads return 0 and neither strobe fires.
- R8: The irq output is the pending interrupt masked by control bit 1. Setting the bit hides a pending interrupt, and clearing the bit shows it again.
- R9: A pending interrupt is cleared by a status read at 10111 or by an accepted command write. A read at 01110 leaves it pending.
- R10: SET FEATURE (0xEF) with feature 0x03 selects the mode from count bits 7:3: 0x00 gives PIO (0), 0x08 gives PIO with flow control (1), 0x20 gives multiword DMA (2), 0x40 gives Ultra DMA (3). Count bits 2:0 go to xfer_sub. Any other feature value completes without changing the mode.
- R11: Any command code other than 0x08, 0xA0, 0xA1, 0xA2 and 0xEF aborts. SET FEATURE 0x03 with count bits 7:3 outside the four listed values also aborts. An abort sets status bit 0, loads 0x04 into the error register and raises the interrupt.
- R12: Control bit 2 (software reset) sets BUSY on the next cycle. It clears DRQ, ERROR, the error register, the pending interrupt and the transfer mode. BUSY stays set for RST_LAT cycles after the write that clears the bit, and no interrupt follows.
- R13: Device reset (0x08) completes with the error register and ERROR both cleared, and it raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 5 | Task-file register address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 16 | Host write data (bits 7:0 for byte registers) |
| host_rdata | output | 16 | Read data for the addressed register |
| disc_state | input | 8 | Medium code ORed with state flags |
| buf_pending | input | 1 | Sector buffer has data to transfer |
| buf_rd_data | input | 16 | Word at the head of the sector buffer |
| buf_rd | output | 1 | Pop strobe to the sector buffer |
| buf_wr | output | 1 | Push strobe to the sector buffer |
| buf_wr_data | output | 16 | Word pushed to the sector buffer |
| cmd_lba | output | 24 | LBA parameter for the command executor |
| irq | output | 1 | Interrupt request to the host |
| xfer_mode | output | 2 | Selected transfer mode |
| xfer_sub | output | 3 | Selected mode number within the transfer mode |

## Verification
The bench builds the block with CMD_LAT = 3 and RST_LAT = 5 rather than the defaults of 2 and 4. Because the two latencies differ, a mix-up between the command countdown and the reset countdown changes the measured number of BUSY status reads. Counting status reads cycle by cycle, the command hold and the reset hold can each be checked with an exact off-by-one margin. A latency longer than one cycle also leaves room to try blocked writes and alternate-status reads while BUSY is still high.

// File: rtl/atf_pkg.sv
package atf_pkg;
  localparam logic [4:0] A_CTL  = 5'b01110;
  localparam logic [4:0] A_DATA = 5'b10000;
  localparam logic [4:0] A_ERR  = 5'b10001;
  localparam logic [4:0] A_CNT  = 5'b10010;
  localparam logic [4:0] A_DISC = 5'b10011;
  localparam logic [4:0] A_LBA1 = 5'b10100;
  localparam logic [4:0] A_LBA2 = 5'b10101;
  localparam logic [4:0] A_DEV  = 5'b10110;
  localparam logic [4:0] A_CMD  = 5'b10111;

  localparam logic [7:0] OP_DEVRST = 8'h08;
  localparam logic [7:0] OP_PKT    = 8'hA0;
  localparam logic [7:0] OP_IDPKT  = 8'hA1;
  localparam logic [7:0] OP_SVC    = 8'hA2;
  localparam logic [7:0] OP_SETF   = 8'hEF;
  localparam logic [7:0] FEAT_XFER = 8'h03;
  localparam logic [7:0] ERR_ABORT = 8'h04;

  typedef enum logic [1:0] {XM_PIO, XM_PIO_FC, XM_MDMA, XM_UDMA} xfer_mode_e;

  typedef struct packed {
    logic [7:0] feature;
    logic [7:0] count;
    logic [7:0] lba0;
    logic [7:0] lba1;
    logic [7:0] lba2;
    logic [7:0] device;
    logic [7:0] command;
    logic       srst;
    logic       nien;
  } tf_regs_t;
endpackage

// File: rtl/atf_regs.sv
module atf_regs
  import atf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [4:0] host_addr,
  input  logic [7:0] wbyte,
  input  logic       wr_open,
  output tf_regs_t   regs,
  output logic       cmd_go
);
  tf_regs_t regs_d;
  logic     any_en;

  always_comb begin
    regs_d = regs;
    any_en = 1'b0;
    cmd_go = 1'b0;
    if (host_wr) begin
      if (host_addr == A_CTL) begin
        regs_d.srst = wbyte[2];
        regs_d.nien = wbyte[1];
        any_en      = 1'b1;
      end else if (wr_open) begin
        any_en = 1'b1;
        unique case (host_addr)
          A_ERR:  regs_d.feature = wbyte;
          A_CNT:  regs_d.count   = wbyte;
          A_DISC: regs_d.lba0    = wbyte;
          A_LBA1: regs_d.lba1    = wbyte;
          A_LBA2: regs_d.lba2    = wbyte;
          A_DEV:  regs_d.device  = wbyte;
          A_CMD: begin
            regs_d.command = wbyte;
            cmd_go         = 1'b1;
          end
          default: any_en = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (any_en) begin
      regs <= regs_d;
    end
  end
endmodule

// File: rtl/atf_seq.sv
module atf_seq
  import atf_pkg::*;
#(
  parameter int CMD_LAT = 2,
  parameter int RST_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       cmd_go,
  input  logic [7:0] command,
  input  logic [7:0] feature,
  input  logic [7:0] count,
  input  logic       buf_pending,
  output logic       busy,
  output logic       drq,
  output logic       err,
  output logic [7:0] errreg,
  output logic       raise,
  output xfer_mode_e xfer_mode,
  output logic [2:0] xfer_sub
);
  localparam int MAXL = (CMD_LAT > RST_LAT) ? CMD_LAT : RST_LAT;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] CMD_LOAD = CW'(CMD_LAT - 1);
  localparam logic [CW-1:0] RST_LOAD = CW'(RST_LAT - 1);

  logic          busy_d, drq_d, err_d, phase_cmd, phase_cmd_d;
  logic [7:0]    errreg_d;
  logic [CW-1:0] cnt, cnt_d;
  xfer_mode_e    mode_d;
  logic [2:0]    sub_d;

  always_comb begin
    busy_d      = busy;
    drq_d       = drq;
    err_d       = err;
    errreg_d    = errreg;
    cnt_d       = cnt;
    phase_cmd_d = phase_cmd;
    mode_d      = xfer_mode;
    sub_d       = xfer_sub;
    raise       = 1'b0;
    if (srst) begin
      busy_d      = 1'b1;
      drq_d       = 1'b0;
      err_d       = 1'b0;
      errreg_d    = '0;
      cnt_d       = RST_LOAD;
      phase_cmd_d = 1'b0;
      mode_d      = XM_PIO;
      sub_d       = '0;
    end else if (cmd_go) begin
      busy_d      = 1'b1;
      err_d       = 1'b0;
      errreg_d    = '0;
      cnt_d       = CMD_LOAD;
      phase_cmd_d = 1'b1;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt_d = cnt - 1'b1;
      end else begin
        busy_d = 1'b0;
        if (phase_cmd) begin
          raise = 1'b1;
          unique case (command)
            OP_DEVRST: begin
              err_d    = 1'b0;
              errreg_d = '0;
            end
            OP_PKT, OP_IDPKT, OP_SVC: begin
              if (buf_pending) begin
                drq_d = 1'b1;
                raise = 1'b0;
              end
            end
            OP_SETF: begin
              if (feature == FEAT_XFER) begin
                sub_d = count[2:0];
                unique case (count[7:3])
                  5'b00000: mode_d = XM_PIO;
                  5'b00001: mode_d = XM_PIO_FC;
                  5'b00100: mode_d = XM_MDMA;
                  5'b01000: mode_d = XM_UDMA;
                  default: begin
                    sub_d    = xfer_sub;
                    err_d    = 1'b1;
                    errreg_d = ERR_ABORT;
                  end
                endcase
              end
            end
            default: begin
              err_d    = 1'b1;
              errreg_d = ERR_ABORT;
            end
          endcase
        end
      end
    end else if (drq && !buf_pending) begin
      drq_d = 1'b0;
      raise = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      drq       <= 1'b0;
      err       <= 1'b0;
      errreg    <= '0;
      cnt       <= '0;
      phase_cmd <= 1'b0;
      xfer_mode <= XM_PIO;
      xfer_sub  <= '0;
    end else begin
      busy      <= busy_d;
      drq       <= drq_d;
      err       <= err_d;
      errreg    <= errreg_d;
      cnt       <= cnt_d;
      phase_cmd <= phase_cmd_d;
      xfer_mode <= mode_d;
      xfer_sub  <= sub_d;
    end
  end
endmodule

// File: rtl/atf_irq.sv
module atf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic raise,
  input  logic clear,
  input  logic nien,
  output logic pend,
  output logic irq
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (srst)       pend_d = 1'b0;
    else if (raise) pend_d = 1'b1;
    else if (clear) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  assign irq = pend & ~nien;
endmodule

// File: rtl/atf_hostmux.sv
module atf_hostmux
  import atf_pkg::*;
(
  input  logic [4:0]  host_addr,
  input  logic        host_rd,
  input  logic        host_wr,
  input  tf_regs_t    regs,
  input  logic [7:0]  status,
  input  logic [7:0]  errreg,
  input  logic [7:0]  disc_state,
  input  logic        drq,
  input  logic [15:0] buf_rd_data,
  output logic [15:0] host_rdata,
  output logic        status_rd,
  output logic        buf_rd,
  output logic        buf_wr
);
  logic at_data;

  assign at_data   = (host_addr == A_DATA);
  assign status_rd = host_rd && (host_addr == A_CMD);
  assign buf_rd    = host_rd && at_data && drq;
  assign buf_wr    = host_wr && at_data && drq;

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      A_CTL, A_CMD: host_rdata[7:0] = status;
      A_ERR:        host_rdata[7:0] = errreg;
      A_CNT:        host_rdata[7:0] = regs.count;
      A_DISC:       host_rdata[7:0] = disc_state;
      A_LBA1:       host_rdata[7:0] = regs.lba1;
      A_LBA2:       host_rdata[7:0] = regs.lba2;
      A_DEV:        host_rdata[7:0] = regs.device;
      A_DATA:       host_rdata      = drq ? buf_rd_data : 16'h0000;
      default:      host_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev
  import atf_pkg::*;
#(
  parameter int CMD_LAT = 2,
  parameter int RST_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  host_addr,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic [7:0]  disc_state,
  input  logic        buf_pending,
  input  logic [15:0] buf_rd_data,
  output logic        buf_rd,
  output logic        buf_wr,
  output logic [15:0] buf_wr_data,
  output logic [23:0] cmd_lba,
  output logic        irq,
  output logic [1:0]  xfer_mode,
  output logic [2:0]  xfer_sub
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  tf_regs_t   tf;
  logic       cmd_go, busy, drq, err, raise, pend, status_rd;
  logic [7:0] errreg, status;
  xfer_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  atf_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .host_wr(host_wr), .host_addr(host_addr),
    .wbyte(host_wdata[7:0]), .wr_open(!busy && !drq), .regs(tf), .cmd_go(cmd_go)
  );

  atf_seq #(.CMD_LAT(CMD_LAT), .RST_LAT(RST_LAT)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .srst(tf.srst), .cmd_go(cmd_go),
    .command(tf.command), .feature(tf.feature), .count(tf.count),
    .buf_pending(buf_pending), .busy(busy), .drq(drq), .err(err),
    .errreg(errreg), .raise(raise), .xfer_mode(mode), .xfer_sub(xfer_sub)
  );

  atf_irq u_irq (
    .clk(clk), .rst_n(rst_sync_n), .srst(tf.srst), .raise(raise),
    .clear(cmd_go || status_rd), .nien(tf.nien), .pend(pend), .irq(irq)
  );

  assign status = {busy, ~busy, 2'b00, drq, 2'b00, err};

  atf_hostmux u_mux (
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr), .regs(tf),
    .status(status), .errreg(errreg), .disc_state(disc_state), .drq(drq),
    .buf_rd_data(buf_rd_data), .host_rdata(host_rdata), .status_rd(status_rd),
    .buf_rd(buf_rd), .buf_wr(buf_wr)
  );

  assign buf_wr_data = host_wdata;
  assign cmd_lba     = {tf.lba2, tf.lba1, tf.lba0};
  assign xfer_mode   = mode;
endmodule

// File: rtl/atf_chk.sv
module atf_chk
  import atf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       host_rd,
  input logic       host_wr,
  input logic [4:0] host_addr,
  input logic       busy,
  input logic       drq,
  input logic       err,
  input logic [7:0] errreg,
  input logic [7:0] count,
  input logic       srst,
  input logic       pend,
  input logic       raise,
  input logic       cmd_go,
  input logic       buf_pending
);
  a_r2_gated_count: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_CNT && (busy || drq)) |=> $stable(count));
  a_r4_busy_drq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && drq));
  a_r5_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !srst) |=> busy);
  a_r6_drain_done: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && !buf_pending && !srst) |=> (!drq && pend));
  a_r9_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_CMD && !raise) |=> !pend);
  a_r9_alt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_CTL && pend && !srst && !cmd_go) |=> pend);
  a_r11_abort_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (errreg == ERR_ABORT));
  a_r12_srst_busy: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (busy && !drq && !pend));
endmodule

bind ata_taskfile_dev atf_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_addr(host_addr), .busy(busy), .drq(drq), .err(err), .errreg(errreg),
  .count(tf.count), .srst(tf.srst), .pend(pend), .raise(raise),
  .cmd_go(cmd_go), .buf_pending(buf_pending)
);

// File: tb/sim_ata_taskfile_dev.sv
`timescale 1ns/1ps
module sim_ata_taskfile_dev;
  localparam int CL = 3;
  localparam int RL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [7:0]  disc_state = 8'h21;
  logic        buf_pending = 1'b0;
  logic [15:0] buf_rd_data = '0;
  logic        buf_rd, buf_wr, irq;
  logic [15:0] buf_wr_data;
  logic [23:0] cmd_lba;
  logic [1:0]  xfer_mode;
  logic [2:0]  xfer_sub;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ata_taskfile_dev #(.CMD_LAT(CL), .RST_LAT(RL)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .disc_state(disc_state), .buf_pending(buf_pending), .buf_rd_data(buf_rd_data),
    .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_wr_data(buf_wr_data), .cmd_lba(cmd_lba),
    .irq(irq), .xfer_mode(xfer_mode), .xfer_sub(xfer_sub)
  );

  // sector buffer stand-in
  logic [15:0] bq[$];
  bit pop_req = 1'b0;
  function automatic void refresh_buf();
    buf_pending = (bq.size() != 0);
    buf_rd_data = (bq.size() != 0) ? bq[0] : 16'h0000;
  endfunction
  always @(negedge clk) pop_req = buf_rd;
  always begin
    @(posedge clk);
    #2;
    if (pop_req && bq.size() != 0) void'(bq.pop_front());
    refresh_buf();
  end

  // behavioural reference model
  logic [7:0] m_feat, m_cnt, m_lba0, m_lba1, m_lba2, m_dev, m_cmd, m_ctl, m_err;
  bit m_busy, m_drq, m_errb, m_pend, m_isc, go, rz, sr, open;
  int m_wait, m_mode, m_sub;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_feat, m_cnt, m_lba0, m_lba1, m_lba2, m_dev, m_cmd, m_ctl, m_err} = '0;
      {m_busy, m_drq, m_errb, m_pend, m_isc} = '0;
      m_wait = 0; m_mode = 0; m_sub = 0;
    end else begin
      go = 0; rz = 0; sr = m_ctl[2]; open = !m_busy && !m_drq;
      if (host_wr && host_addr == 5'b10111 && open) go = 1;
      if (sr) begin
        m_busy = 1; m_drq = 0; m_errb = 0; m_err = 0; m_wait = RL - 1;
        m_isc = 0; m_mode = 0; m_sub = 0;
      end else if (go) begin
        m_busy = 1; m_errb = 0; m_err = 0; m_wait = CL - 1; m_isc = 1;
      end else if (m_busy) begin
        if (m_wait > 0) m_wait--;
        else begin
          m_busy = 0;
          if (m_isc) begin
            rz = 1;
            if (m_cmd == 8'h08) begin m_errb = 0; m_err = 0; end
            else if (m_cmd inside {8'hA0, 8'hA1, 8'hA2}) begin
              if (buf_pending) begin m_drq = 1; rz = 0; end
            end else if (m_cmd == 8'hEF) begin
              if (m_feat == 8'h03) begin
                case (m_cnt & 8'hF8)
                  8'h00: begin m_mode = 0; m_sub = m_cnt & 7; end
                  8'h08: begin m_mode = 1; m_sub = m_cnt & 7; end
                  8'h20: begin m_mode = 2; m_sub = m_cnt & 7; end
                  8'h40: begin m_mode = 3; m_sub = m_cnt & 7; end
                  default: begin m_errb = 1; m_err = 8'h04; end
                endcase
              end
            end else begin m_errb = 1; m_err = 8'h04; end
          end
        end
      end else if (m_drq && !buf_pending) begin
        m_drq = 0; rz = 1;
      end
      if (sr) m_pend = 0;
      else if (rz) m_pend = 1;
      else if (go || (host_rd && host_addr == 5'b10111)) m_pend = 0;
      if (host_wr) begin
        if (host_addr == 5'b01110) m_ctl = host_wdata[7:0];
        else if (open) begin
          case (host_addr)
            5'b10001: m_feat = host_wdata[7:0];
            5'b10010: m_cnt  = host_wdata[7:0];
            5'b10011: m_lba0 = host_wdata[7:0];
            5'b10100: m_lba1 = host_wdata[7:0];
            5'b10101: m_lba2 = host_wdata[7:0];
            5'b10110: m_dev  = host_wdata[7:0];
            5'b10111: m_cmd  = host_wdata[7:0];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [15:0] m_read(input logic [4:0] a);
    logic [7:0] st;
    st = {m_busy, !m_busy, 2'b00, m_drq, 2'b00, m_errb};
    case (a)
      5'b01110, 5'b10111: return {8'h00, st};
      5'b10001: return {8'h00, m_err};
      5'b10010: return {8'h00, m_cnt};
      5'b10011: return {8'h00, disc_state};
      5'b10100: return {8'h00, m_lba1};
      5'b10101: return {8'h00, m_lba2};
      5'b10110: return {8'h00, m_dev};
      5'b10000: return m_drq ? buf_rd_data : 16'h0000;
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R3 rdata", host_rdata, m_read(host_addr));
      cmp("R8 irq", irq, m_pend && !m_ctl[1]);
      cmp("R7 buf_rd", buf_rd, host_rd && host_addr == 5'b10000 && m_drq);
      cmp("R7 buf_wr", buf_wr, host_wr && host_addr == 5'b10000 && m_drq);
      cmp("R10 mode", {xfer_sub, xfer_mode}, {m_sub[2:0], m_mode[1:0]});
      cmp("R3 lba", cmd_lba, {m_lba2, m_lba1, m_lba0});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    v = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rchk(input string tag, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    cmp(tag, v, exp);
  endtask

  task automatic issue(input logic [7:0] c);
    wr(5'b10111, {8'h00, c});
    idle(CL + 2);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int nb;
    logic [15:0] v;
    refresh_buf();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rchk("R1 status", 5'b10111, 16'h0040);
    rchk("R1 error", 5'b10001, 16'h0000);
    cmp("R1 irq", irq, 1'b0);
    cmp("R1 mode", {xfer_sub, xfer_mode}, 5'd0);
    // R3 register decode and disc status
    wr(5'b10100, 16'h0011); wr(5'b10101, 16'h0022); wr(5'b10110, 16'h00B0);
    rchk("R3 lba1", 5'b10100, 16'h0011);
    rchk("R3 lba2", 5'b10101, 16'h0022);
    rchk("R3 device", 5'b10110, 16'h00B0);
    rchk("R3 disc", 5'b10011, 16'h0021);
    wr(5'b10011, 16'h0077);
    rchk("R3 disc after lba0 write", 5'b10011, 16'h0021);
    cmp("R3 cmd_lba", cmd_lba, 24'h221177);
    // R5 / R10 set feature multiword DMA mode 2
    wr(5'b10001, 16'h0003); wr(5'b10010, 16'h0022);
    wr(5'b10111, 16'h00EF);
    nb = 0;
    for (int i = 0; i < 10; i++) begin
      rd(5'b01110, v);
      if (v[7]) nb++;
      else break;
    end
    cmp("R5 busy cycles", nb, CL);
    cmp("R10 mode mdma", {xfer_sub, xfer_mode}, {3'd2, 2'd2});
    cmp("R9 irq raised", irq, 1'b1);
    // R9 alternate read keeps, status read clears
    rchk("R9 alt status", 5'b01110, 16'h0040);
    cmp("R9 alt keeps irq", irq, 1'b1);
    rchk("R4 status", 5'b10111, 16'h0040);
    cmp("R9 status clears irq", irq, 1'b0);
    // R10 other modes
    wr(5'b10010, 16'h0044); issue(8'hEF);
    cmp("R10 mode udma", {xfer_sub, xfer_mode}, {3'd4, 2'd3});
    wr(5'b10010, 16'h0009); issue(8'hEF);
    cmp("R10 mode pio flow", {xfer_sub, xfer_mode}, {3'd1, 2'd1});
    wr(5'b10001, 16'h0055); wr(5'b10010, 16'h0040); issue(8'hEF);
    cmp("R10 other feature ignored", {xfer_sub, xfer_mode}, {3'd1, 2'd1});
    // R11 aborts
    issue(8'h55);
    rchk("R11 status err", 5'b01110, 16'h0041);
    rchk("R11 errreg", 5'b10001, 16'h0004);
    cmp("R11 irq", irq, 1'b1);
    // R8 masking
    wr(5'b01110, 16'h0002);
    cmp("R8 masked", irq, 1'b0);
    wr(5'b01110, 16'h0000);
    cmp("R8 unmasked", irq, 1'b1);
    wr(5'b10001, 16'h0003); wr(5'b10010, 16'h0030); issue(8'hEF);
    rchk("R11 bad mode", 5'b10111, 16'h0041);
    cmp("R11 mode kept", {xfer_sub, xfer_mode}, {3'd1, 2'd1});
    // R13 device reset
    issue(8'h08);
    rchk("R13 errreg", 5'b10001, 16'h0000);
    rchk("R13 status", 5'b10111, 16'h0040);
    // R6 identify with no data
    issue(8'hA1);
    cmp("R6 no data irq", irq, 1'b1);
    rchk("R6 no data status", 5'b10111, 16'h0040);
    // R6 / R7 / R2 packet with data
    bq.push_back(16'hCAFE); bq.push_back(16'h1234); refresh_buf();
    wr(5'b10010, 16'h0022);
    issue(8'hA0);
    rchk("R4 drq status", 5'b10111, 16'h0048);
    wr(5'b10010, 16'h0099);
    rchk("R2 count blocked", 5'b10010, 16'h0022);
    wr(5'b10111, 16'h0055);
    rchk("R2 cmd blocked", 5'b10111, 16'h0048);
    wr(5'b10000, 16'hBEEF);
    rchk("R7 data word0", 5'b10000, 16'hCAFE);
    rchk("R7 data word1", 5'b10000, 16'h1234);
    idle(3);
    cmp("R6 drain irq", irq, 1'b1);
    rchk("R6 drq cleared", 5'b10111, 16'h0040);
    rchk("R7 data idle", 5'b10000, 16'h0000);
    wr(5'b10000, 16'h5555);
    // R12 software reset
    wr(5'b10010, 16'h0008); wr(5'b10001, 16'h0003); issue(8'hEF);
    wr(5'b01110, 16'h0004);
    idle(1);
    rchk("R12 busy", 5'b01110, 16'h0080);
    cmp("R12 irq cleared", irq, 1'b0);
    cmp("R12 mode cleared", {xfer_sub, xfer_mode}, 5'd0);
    wr(5'b10010, 16'h0066);
    wr(5'b01110, 16'h0000);
    nb = 0;
    for (int i = 0; i < 12; i++) begin
      rd(5'b01110, v);
      if (v[7]) nb++;
      else break;
    end
    cmp("R12 busy cycles", nb, RL);
    cmp("R12 no irq", irq, 1'b0);
    rchk("R2 count blocked in reset", 5'b10010, 16'h0008);
    idle(2);
    summary();
  end
endmodule